// File: doc/BRIEF.md
# JTAG Streaming FIFO Bridge

This block sits on the target side of a JTAG link. It reads one long data-register shift as a framed transaction made of WW-bit words. It takes TCK, TDI and the capture, shift and update strobes from a TAP controller and drives TDO. On the logic side it pushes words into a write FIFO and pops words from a first-word-fall-through read FIFO. Both FIFOs report their fill level as a word count.

The first word of a frame selects the message type. An all-ones first word marks a control message. In that case the second word either asks for the build parameters (when it is zero) or loads the side-channel register (when it is nonzero). Any other first word is the write request size of a data exchange, and the second word is the read request size. Payload words follow the two size words, and two padding words close the frame. Write words are sent without waiting for permission. The two response words at the end of the frame report how many writes were taken and how many reads were delivered, so the host can resend what was dropped.

Top module: `jtag_fifo_bridge`

## Requirements
- R1: A frame whose word 0 is all ones and whose word 1 is zero returns 0 in response word 0, the parameter WW in word 1 and the parameter DEPTH in word 2. It changes neither sc_out nor the FIFOs.
- R2: A frame whose word 0 is all ones and whose word 1 is nonzero returns 0 in response word 0. At the end of word 1 it loads word 1 into sc_out. It causes no FIFO push and no pop.
- R3: Bits move least-significant bit first on both TDI and TDO. The response bit for shift cycle k is on TDO before the clock edge that samples TDI bit k. A capture strobe restarts framing at word 0, bit 0, and response words 0 and 1 of a data frame are zero.
- R4: In a data frame, the accepted write count A is min(word 0, wr_free sampled at capture). Exactly the first A payload words (words 2 to A+1) are pushed, in order. The other payload words are dropped.
- R5: In a data frame, the delivered read count D is min(word 1, rd_avail sampled at capture). Response words 2 to D+1 carry successive read-FIFO words, each followed by one pop. Any later payload slots respond 0.
- R6: With n = max(word 0, word 1), response word n+2 is A and response word n+3 is D.
- R7: After an update strobe, shift cycles that come before the next capture push nothing, pop nothing, leave sc_out unchanged and leave TDO unchanged.
- R8: After reset, tdo, wr_valid, rd_pop and sc_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data from the host |
| capture_dr | input | 1 | Data register capture state strobe |
| shift_dr | input | 1 | Data register shift state strobe |
| update_dr | input | 1 | Data register update state strobe |
| tdo | output | 1 | Serial response to the host |
| wr_data | output | WW | Word pushed into the write FIFO |
| wr_valid | output | 1 | One-cycle push strobe |
| wr_free | input | WW | Free word count of the write FIFO |
| rd_data | input | WW | Head word of the read FIFO |
| rd_pop | output | 1 | One-cycle pop strobe |
| rd_avail | input | WW | Stored word count of the read FIFO |
| sc_out | output | WW | Side-channel register |

## Verification
A wrong bit or word counter shows up on TDO in the very next response word as a misaligned or shifted value. It also puts wr_valid pulses at the wrong word boundary, which corrupts the recorded push sequence. A wrong snapshot of the FIFO levels, or a wrong min computation, changes the trailing count words and the number of pushes or pops within the same frame. A mode decoded wrongly from word 0 turns a control message into FIFO traffic, or the reverse, and the parameter words or sc_out show it at once.

// File: rtl/jtag_fifo_bridge.sv
module jtag_fifo_bridge #(
  parameter int WW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          tck,
  input  logic          rst_n,
  input  logic          tdi,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  output logic          tdo,
  output logic [WW-1:0] wr_data,
  output logic          wr_valid,
  input  logic [WW-1:0] wr_free,
  input  logic [WW-1:0] rd_data,
  output logic          rd_pop,
  input  logic [WW-1:0] rd_avail,
  output logic [WW-1:0] sc_out
);
  localparam int BW = (WW > 1) ? $clog2(WW) : 1;
  localparam int IW = WW + 2;
  localparam logic [WW-1:0] MARK       = '1;
  localparam logic [WW-1:0] WW_CODE    = WW'(WW);
  localparam logic [WW-1:0] DEPTH_CODE = WW'(DEPTH);
  localparam logic [BW-1:0] LAST_BIT   = BW'(WW - 1);

  logic          active, ctrl;
  logic [BW-1:0] bit_cnt;
  logic [IW-1:0] idx, plen;
  logic [WW-1:0] in_sr, out_sr;
  logic [WW-1:0] free_s, avail_s, wr_req, wr_acc, rd_acc;

  logic          step, word_end, load_rd, push_now, rd_slot;
  logic [WW-1:0] word_now, next_resp, wr_acc_now, rd_acc_now, big_req;
  logic [IW-1:0] nidx, plen_now;

  assign step       = active && shift_dr;
  assign word_end   = step && (bit_cnt == LAST_BIT);
  assign word_now   = {tdi, in_sr[WW-1:1]};
  assign nidx       = idx + 1'b1;
  assign wr_acc_now = (word_now < free_s) ? word_now : free_s;
  assign rd_acc_now = (idx == 1) ? ((word_now < avail_s) ? word_now : avail_s) : rd_acc;
  assign big_req    = (word_now > wr_req) ? word_now : wr_req;
  assign plen_now   = (idx == 1) ? {2'b00, big_req} : plen;
  assign rd_slot    = (nidx >= 2) && ((nidx - 2) < {2'b00, rd_acc_now});
  assign push_now   = !ctrl && (idx >= 2) && ((idx - 2) < {2'b00, wr_acc});
  assign tdo        = out_sr[0];

  always_comb begin
    next_resp = '0;
    load_rd   = 1'b0;
    if (idx == 0)
      next_resp = (word_now == MARK) ? WW_CODE : '0;
    else if (ctrl)
      next_resp = (idx == 1) ? DEPTH_CODE : '0;
    else if (rd_slot) begin
      next_resp = rd_data;
      load_rd   = 1'b1;
    end else if (nidx == plen_now + 2)
      next_resp = wr_acc;
    else if (nidx == plen_now + 3)
      next_resp = rd_acc_now;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; ctrl <= 1'b0; bit_cnt <= '0; idx <= '0; plen <= '0;
      in_sr <= '0; out_sr <= '0; free_s <= '0; avail_s <= '0;
      wr_req <= '0; wr_acc <= '0; rd_acc <= '0;
      wr_data <= '0; wr_valid <= 1'b0; rd_pop <= 1'b0; sc_out <= '0;
    end else begin
      wr_valid <= 1'b0;
      rd_pop   <= 1'b0;
      if (capture_dr) begin
        active <= 1'b1; ctrl <= 1'b0; bit_cnt <= '0; idx <= '0; plen <= '0;
        out_sr <= '0; free_s <= wr_free; avail_s <= rd_avail;
        wr_req <= '0; wr_acc <= '0; rd_acc <= '0;
      end else if (update_dr) begin
        active <= 1'b0;
      end else if (step) begin
        in_sr <= word_now;
        if (word_end) begin
          bit_cnt <= '0;
          idx     <= nidx;
          out_sr  <= next_resp;
          if (idx == 0) begin
            ctrl   <= (word_now == MARK);
            wr_req <= word_now;
            wr_acc <= wr_acc_now;
          end
          if (idx == 1) begin
            if (ctrl) begin
              if (word_now != '0) sc_out <= word_now;
            end else begin
              rd_acc <= rd_acc_now;
              plen   <= plen_now;
            end
          end
          if (push_now) begin
            wr_valid <= 1'b1;
            wr_data  <= word_now;
          end
          if (load_rd) rd_pop <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          out_sr  <= {1'b0, out_sr[WW-1:1]};
        end
      end
    end
  end

  logic [IW-1:0] push_cnt, pop_cnt;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      push_cnt <= '0; pop_cnt <= '0;
    end else if (capture_dr) begin
      push_cnt <= '0; pop_cnt <= '0;
    end else begin
      if (wr_valid) push_cnt <= push_cnt + 1'b1;
      if (rd_pop)   pop_cnt  <= pop_cnt + 1'b1;
    end
  end

  assert_push_bound_R4: assert property (@(posedge tck) disable iff (!rst_n)
    wr_valid |-> (push_cnt < {2'b00, wr_acc}));
  assert_pop_bound_R5: assert property (@(posedge tck) disable iff (!rst_n)
    rd_pop |-> (pop_cnt < {2'b00, rd_acc}));
  assert_no_push_ctrl_R2: assert property (@(posedge tck) disable iff (!rst_n)
    wr_valid |-> !ctrl);
  assert_sc_only_ctrl_R2: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(sc_out) |-> ctrl);
  assert_tdo_hold_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_dr && !capture_dr) |=> $stable(tdo));
endmodule

// File: tb/jtag_fifo_bridge_tb.sv
module jtag_fifo_bridge_tb_top;
  localparam int WW = 16;
  logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic tdo, wr_valid, rd_pop;
  logic [WW-1:0] wr_data, wr_free = '0, rd_data, rd_avail = '0, sc_out;

  int checks = 0, failures = 0;
  logic [WW-1:0] req_w [0:15];
  logic [WW-1:0] rsp_w [0:15];
  logic [WW-1:0] push_log [0:15];
  logic [WW-1:0] rd_mem [0:31];
  int push_n = 0, rd_ptr = 0;

  always #2 tck = ~tck;

  jtag_fifo_bridge #(.WW(WW), .DEPTH(8)) dut_i (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdo(tdo),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_free(wr_free),
    .rd_data(rd_data), .rd_pop(rd_pop), .rd_avail(rd_avail), .sc_out(sc_out));

  assign rd_data = rd_mem[rd_ptr % 32];

  always @(posedge tck) if (rst_n) begin
    if (wr_valid) begin push_log[push_n % 16] <= wr_data; push_n <= push_n + 1; end
    if (rd_pop) rd_ptr <= rd_ptr + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int n);
    @(negedge tck) capture_dr = 1'b1;
    @(negedge tck) capture_dr = 1'b0; shift_dr = 1'b1;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < WW; b++) begin
        tdi = req_w[w][b];
        rsp_w[w][b] = tdo;
        @(negedge tck);
      end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck) update_dr = 1'b0;
    repeat (3) @(negedge tck);
  endtask

  task automatic set_req(input logic [WW-1:0] a, b, c, d, e, f, g, h, i);
    req_w[0] = a; req_w[1] = b; req_w[2] = c; req_w[3] = d; req_w[4] = e;
    req_w[5] = f; req_w[6] = g; req_w[7] = h; req_w[8] = i;
  endtask

  task automatic t_reset;
    chk("R8 tdo", tdo, 0);
    chk("R8 wr_valid", wr_valid, 0);
    chk("R8 rd_pop", rd_pop, 0);
    chk("R8 sc_out", sc_out, 0);
  endtask

  task automatic t_discovery(input string tag);
    int p0 = push_n, r0 = rd_ptr;
    logic [WW-1:0] s0 = sc_out;
    set_req('1, 0, 0, 0, 0, 0, 0, 0, 0);
    run_frame(3);
    chk({tag, " word0"}, rsp_w[0], 0);
    chk({tag, " word1 width"}, rsp_w[1], 16);
    chk({tag, " word2 depth"}, rsp_w[2], 8);
    chk({tag, " sc unchanged"}, sc_out, s0);
    chk({tag, " no fifo traffic"}, (push_n - p0) + (rd_ptr - r0), 0);
  endtask

  task automatic t_side;
    int p0 = push_n, r0 = rd_ptr;
    set_req('1, 16'h00A5, 0, 0, 0, 0, 0, 0, 0);
    run_frame(3);
    chk("R2 word0", rsp_w[0], 0);
    chk("R2 sc_out", sc_out, 16'h00A5);
    chk("R2 no fifo traffic", (push_n - p0) + (rd_ptr - r0), 0);
  endtask

  task automatic t_near_full;
    int p0 = push_n, r0 = rd_ptr;
    wr_free = 2; rd_avail = 0;
    set_req(5, 0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 0, 0);
    run_frame(9);
    chk("R3 data word0 zero", rsp_w[0], 0);
    chk("R3 data word1 zero", rsp_w[1], 0);
    for (int k = 2; k < 7; k++) chk("R5 empty read slot", rsp_w[k], 0);
    chk("R6 write count", rsp_w[7], 2);
    chk("R6 read count", rsp_w[8], 0);
    chk("R4 push count", push_n - p0, 2);
    chk("R4 push first", push_log[p0 % 16], 16'h1111);
    chk("R4 push second", push_log[(p0 + 1) % 16], 16'h2222);
    chk("R5 no pops", rd_ptr - r0, 0);
  endtask

  task automatic t_near_empty;
    int p0 = push_n, r0 = rd_ptr;
    wr_free = 8; rd_avail = 1;
    set_req(0, 3, 0, 0, 0, 0, 0, 0, 0);
    run_frame(7);
    chk("R5 read word", rsp_w[2], rd_mem[r0 % 32]);
    chk("R5 zero slot a", rsp_w[3], 0);
    chk("R5 zero slot b", rsp_w[4], 0);
    chk("R6 write count zero", rsp_w[5], 0);
    chk("R6 read count one", rsp_w[6], 1);
    chk("R5 pop count", rd_ptr - r0, 1);
    chk("R4 no pushes", push_n - p0, 0);
  endtask

  task automatic t_mixed;
    int p0 = push_n, r0 = rd_ptr;
    wr_free = 8; rd_avail = 4;
    set_req(3, 2, 16'hAAA1, 16'hBBB2, 16'hCCC3, 0, 0, 0, 0);
    run_frame(7);
    chk("R5 mixed read0", rsp_w[2], rd_mem[r0 % 32]);
    chk("R5 mixed read1", rsp_w[3], rd_mem[(r0 + 1) % 32]);
    chk("R5 mixed zero", rsp_w[4], 0);
    chk("R6 mixed wcount", rsp_w[5], 3);
    chk("R6 mixed rcount", rsp_w[6], 2);
    chk("R4 mixed pushes", push_n - p0, 3);
    chk("R4 mixed third", push_log[(p0 + 2) % 16], 16'hCCC3);
    chk("R5 mixed pops", rd_ptr - r0, 2);
  endtask

  task automatic t_idle_shift;
    int p0 = push_n, r0 = rd_ptr, changed = 0;
    logic t0 = tdo;
    logic [WW-1:0] s0 = sc_out;
    @(negedge tck) shift_dr = 1'b1; tdi = 1'b1;
    repeat (3 * WW) begin
      @(negedge tck);
      if (tdo !== t0) changed++;
    end
    shift_dr = 1'b0; tdi = 1'b0;
    repeat (3) @(negedge tck);
    chk("R7 tdo held", changed, 0);
    chk("R7 no fifo traffic", (push_n - p0) + (rd_ptr - r0), 0);
    chk("R7 sc held", sc_out, s0);
  endtask

  task automatic t_restart;
    @(negedge tck) capture_dr = 1'b1;
    @(negedge tck) capture_dr = 1'b0; shift_dr = 1'b1; tdi = 1'b1;
    repeat (10) @(negedge tck);
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck) update_dr = 1'b0; tdi = 1'b0;
    t_discovery("R3 restart");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rd_mem[i] = 16'hC000 + 16'(i * 3 + 1);
    repeat (2) @(negedge tck);
    t_reset();
    rst_n = 1'b1;
    @(negedge tck);
    t_discovery("R1");
    t_side();
    t_near_full();
    t_near_empty();
    t_mixed();
    t_idle_shift();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule